// File: doc/BRIEF.md
# Device-to-Host Endpoint Transmit Buffer

This block manages a single byte buffer that feeds a device-to-host endpoint. Local logic raises a request, receives a grant while the buffer is open, and writes bytes one per cycle with a put strobe. The buffer is closed in one of two ways. A put can land in the last free location, or local logic can send a done pulse while the buffer is still partly filled. Closing the buffer drops the free flag without any further action from local logic.

A closed buffer waits for an IN token indication from the host side. The token starts a burst that streams the stored bytes one per cycle on the transmit port. An end marker follows the last byte, and the block then waits for the host's acknowledge. If another token arrives before an acknowledge, the same bytes are sent again from the start. The acknowledge empties the buffer, reopens it for filling and raises a one-cycle acked pulse. The stored byte count is visible at all times so the sender can build its packet header.

Top module: `dev_in_txbuf`

## Requirements
- R1: After reset the buffer is open and empty: free is 1, tx_len is 0, and tx_valid, tx_end, acked and stall are 0.
- R2: fill_grant is 1 exactly when fill_req is 1 and the buffer is open for filling. It is 0 while the buffer is closed, sending or awaiting an acknowledge.
- R3: A put with fill_req high is accepted on a clock edge while the buffer is open and holds fewer than DEPTH bytes. The byte is stored at the next write position, and tx_len rises by one after that edge.
- R4: When a put fills the last location, free falls after that same edge with no done pulse, and the buffer is closed.
- R5: A done pulse with fill_req high closes an open buffer and drops free, and tx_len keeps the count. If a put arrives in the same cycle as the done pulse, that byte is stored before the buffer closes.
- R6: A buffer closed with zero bytes sends a zero-length packet. After the token comes one tx_end cycle and no tx_valid cycle.
- R7: An IN token (tok_in) on a closed buffer starts sending in the next cycle. tx_valid is high for tx_len consecutive cycles, and tx_data carries the bytes in write order. These cycles are followed by exactly one cycle with tx_end high and tx_valid low.
- R8: A put is ignored if it is not accepted, that is, without fill_req, outside the open state, or when the buffer is full. The stored bytes and tx_len do not change, and stall is high for the one cycle after the edge that saw the ignored put.
- R9: A token that arrives while the block awaits an acknowledge resends the same tx_len bytes from the first location.
- R10: An acknowledge (host_ack) while the block awaits one makes acked high for exactly the next cycle. After the same edge the buffer is empty (tx_len 0) and free is 1 again. An acknowledge in any other state produces no acked pulse.
- R11: A token while the buffer is open produces no tx_valid and no tx_end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fill_req | input | 1 | Local logic requests write access |
| fill_grant | output | 1 | Write access granted |
| put | input | 1 | Write strobe for put_data |
| put_data | input | DATA_W | Byte to store |
| done | input | 1 | Close a partly filled buffer |
| free | output | 1 | Buffer open with room for a byte |
| stall | output | 1 | One-cycle pulse after an ignored put |
| acked | output | 1 | One-cycle pulse after an accepted acknowledge |
| tok_in | input | 1 | IN token seen by the host side |
| host_ack | input | 1 | Host acknowledged the sent data |
| tx_valid | output | 1 | tx_data carries a buffer byte |
| tx_data | output | DATA_W | Streamed byte |
| tx_end | output | 1 | End of the packet being sent |
| tx_len | output | $clog2(DEPTH+1) | Stored byte count |

## Verification
The bench builds the block with DEPTH set to 4. With that size a full buffer is reached in four puts, so the automatic close and the dropped fifth put happen in short scenarios. The count also reaches DEPTH, a value that needs the extra bit of tx_len. These scenarios run alongside partial fills, an empty packet, a resend on a repeated token, and tokens, acknowledges and puts that arrive in the wrong state.

// File: rtl/txbuf_pkg.sv
// Shared types for the device-to-host transmit buffer.
// Assumes: the four buffer phases below are the only states.
package txbuf_pkg;
    typedef enum logic [1:0] {
        ST_FILL     = 2'd0,
        ST_READY    = 2'd1,
        ST_SEND     = 2'd2,
        ST_WAIT_ACK = 2'd3
    } buf_state_t;
endpackage

// File: rtl/txbuf_store.sv
// Byte storage with a write count.
// Assumes: wr_en is only raised when count < DEPTH; clr empties the buffer.
module txbuf_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [CW-1:0]     count
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Write the incoming byte at the current fill position.
    always_ff @(posedge clk) begin
        if (wr_en) mem[count[AW-1:0]] <= wr_data;
    end

    // Track how many bytes the buffer holds.
    always_ff @(posedge clk) begin
        if (!rst_n)     count <= '0;
        else if (clr)   count <= '0;
        else if (wr_en) count <= count + 1'b1;
    end

    // Asynchronous read port for the streaming side.
    assign rd_data = mem[rd_addr];

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> (count == $past(count) + 1'b1));
    // R8
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !clr) |=> $stable(count));
endmodule

// File: rtl/txbuf_reader.sv
// Streams the stored bytes after a token, then flags end of packet.
// Assumes: start is a single-cycle pulse and count is stable while sending.
module txbuf_reader #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              sending,
    input  logic [CW-1:0]     count,
    input  logic [DATA_W-1:0] rd_data,
    output logic [AW-1:0]     rd_addr,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              send_end
);
    logic [CW-1:0] rd_ptr;

    // Rewind on start, then step once per sent byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                         rd_ptr <= '0;
        else if (start)                     rd_ptr <= '0;
        else if (sending && rd_ptr < count) rd_ptr <= rd_ptr + 1'b1;
    end

    // Present the byte under the pointer and the end marker.
    always_comb begin
        rd_addr  = rd_ptr[AW-1:0];
        tx_valid = sending && (rd_ptr < count);
        tx_data  = tx_valid ? rd_data : '0;
        send_end = sending && (rd_ptr == count);
    end

    // R7
    end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid && send_end));
endmodule

// File: rtl/txbuf_ctrl.sv
// Buffer phase controller: grant, free flag, close, send and recycle.
// Assumes: tok_in and host_ack are single-cycle indications.
module txbuf_ctrl
    import txbuf_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fill_req,
    input  logic          put,
    input  logic          done,
    input  logic          tok_in,
    input  logic          host_ack,
    input  logic [CW-1:0] count,
    input  logic          send_end,
    output logic          fill_grant,
    output logic          free,
    output logic          wr_en,
    output logic          clr,
    output logic          start,
    output logic          sending,
    output logic          stall,
    output logic          acked
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);
    localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

    buf_state_t state, state_nx;
    logic closing;

    // Decode handshakes for the current phase.
    always_comb begin
        fill_grant = fill_req && (state == ST_FILL);
        free       = (state == ST_FILL) && (count != FULL);
        wr_en      = fill_grant && put && (count != FULL);
        closing    = fill_grant && (done || (wr_en && count == LAST));
        clr        = (state == ST_WAIT_ACK) && host_ack;
        start      = tok_in && !clr &&
                     ((state == ST_READY) || (state == ST_WAIT_ACK));
        sending    = (state == ST_SEND);
    end

    // Select the next buffer phase.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FILL:     if (closing)  state_nx = ST_READY;
            ST_READY:    if (start)    state_nx = ST_SEND;
            ST_SEND:     if (send_end) state_nx = ST_WAIT_ACK;
            ST_WAIT_ACK: if (clr)      state_nx = ST_FILL;
                         else if (start) state_nx = ST_SEND;
            default:     state_nx = ST_FILL;
        endcase
    end

    // Hold the phase and the one-cycle status pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_FILL;
            stall <= 1'b0;
            acked <= 1'b0;
        end else begin
            state <= state_nx;
            stall <= put && !wr_en;
            acked <= clr;
        end
    end

    // R4
    full_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && count == LAST) |=> (state == ST_READY));
    // R5
    done_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_grant && done) |=> (state == ST_READY));
    // R10
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_WAIT_ACK) && host_ack) |=> (acked && state == ST_FILL));
    // R10
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acked |=> !acked);
    // R7
    send_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SEND) && send_end) |=> (state == ST_WAIT_ACK));
    // R11
    fill_tok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_FILL) && !closing) |=> (state == ST_FILL));
endmodule

// File: rtl/dev_in_txbuf.sv
// Device-to-host endpoint transmit buffer top.
// Assumes: one buffer; local logic fills, the host side drains on a token.
module dev_in_txbuf #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_req,
    output logic              fill_grant,
    input  logic              put,
    input  logic [DATA_W-1:0] put_data,
    input  logic              done,
    output logic              free,
    output logic              stall,
    output logic              acked,
    input  logic              tok_in,
    input  logic              host_ack,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_end,
    output logic [CW-1:0]     tx_len
);
    logic              wr_en, clr, start, sending, send_end;
    logic [AW-1:0]     rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic [CW-1:0]     count;

    txbuf_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .fill_req(fill_req), .put(put),
        .done(done), .tok_in(tok_in), .host_ack(host_ack), .count(count),
        .send_end(send_end), .fill_grant(fill_grant), .free(free),
        .wr_en(wr_en), .clr(clr), .start(start), .sending(sending),
        .stall(stall), .acked(acked)
    );

    txbuf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(put_data),
        .clr(clr), .rd_addr(rd_addr), .rd_data(rd_data), .count(count)
    );

    txbuf_reader #(.DATA_W(DATA_W), .DEPTH(DEPTH)) reader_i (
        .clk(clk), .rst_n(rst_n), .start(start), .sending(sending),
        .count(count), .rd_data(rd_data), .rd_addr(rd_addr),
        .tx_valid(tx_valid), .tx_data(tx_data), .send_end(send_end)
    );

    assign tx_end = send_end;
    assign tx_len = count;
endmodule

// File: tb/dev_in_txbuf_tb_top.sv
// Directed bench for the transmit buffer, DEPTH = 4.
module dev_in_txbuf_tb_top;
    localparam int DW = 8;
    localparam int DP = 4;
    localparam int CW = $clog2(DP + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic fill_req = 0, put = 0, done = 0, tok_in = 0, host_ack = 0;
    logic [DW-1:0] put_data = '0;
    logic fill_grant, free, stall, acked, tx_valid, tx_end;
    logic [DW-1:0] tx_data;
    logic [CW-1:0] tx_len;
    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    dev_in_txbuf #(.DATA_W(DW), .DEPTH(DP)) dut_i (.*);

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_put(input logic [DW-1:0] d, input logic with_done);
        fill_req = 1; put = 1; put_data = d; done = with_done;
        tick();
        put = 0; done = 0;
    endtask

    // Token, then expect n bytes from v in order and one end cycle (R7).
    task automatic send_check(input logic [DW-1:0] v [4], input int n, input string req);
        tok_in = 1; tick(); tok_in = 0;
        for (int i = 0; i < n; i++) begin
            chk({req, " valid"}, int'(tx_valid), 1);
            chk({req, " data"}, int'(tx_data), int'(v[i]));
            tick();
        end
        chk({req, " end"}, int'(tx_end), 1);
        chk({req, " no valid at end"}, int'(tx_valid), 0);
        tick();
        chk({req, " end single"}, int'(tx_end), 0);
    endtask

    task automatic ack_check();
        host_ack = 1; tick(); host_ack = 0;
        chk("R10 acked", int'(acked), 1);
        chk("R10 free back", int'(free), 1);
        chk("R10 len cleared", int'(tx_len), 0);
        tick();
        chk("R10 acked one cycle", int'(acked), 0);
    endtask

    task automatic t_reset();
        chk("R1 free", int'(free), 1);
        chk("R1 len", int'(tx_len), 0);
        chk("R1 valid", int'(tx_valid), 0);
        chk("R1 end", int'(tx_end), 0);
        chk("R1 acked", int'(acked), 0);
        chk("R1 stall", int'(stall), 0);
        fill_req = 1; #1;
        chk("R2 grant open", int'(fill_grant), 1);
        fill_req = 0; #1;
        chk("R2 no req no grant", int'(fill_grant), 0);
    endtask

    task automatic t_partial();
        logic [DW-1:0] v [4] = '{8'hA1, 8'hB2, 8'hC3, 8'h00};
        do_put(8'hA1, 0);
        chk("R3 len 1", int'(tx_len), 1);
        do_put(8'hB2, 0);
        do_put(8'hC3, 1);
        chk("R5 closed free", int'(free), 0);
        chk("R5 len with same-cycle put", int'(tx_len), 3);
        #1;
        chk("R2 no grant closed", int'(fill_grant), 0);
        do_put(8'hEE, 0);
        chk("R8 stall after closed put", int'(stall), 1);
        chk("R8 len unchanged", int'(tx_len), 3);
        fill_req = 0;
        tick();
        chk("R8 stall single", int'(stall), 0);
        send_check(v, 3, "R7");
        host_ack = 0;
        send_check(v, 3, "R9 resend");
        ack_check();
    endtask

    task automatic t_full();
        logic [DW-1:0] v [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
        for (int i = 0; i < 3; i++) do_put(v[i], 0);
        chk("R4 free before last", int'(free), 1);
        do_put(v[3], 0);
        chk("R4 free drops on full", int'(free), 0);
        chk("R4 len full", int'(tx_len), 4);
        do_put(8'h55, 0);
        chk("R8 stall when full", int'(stall), 1);
        chk("R8 len still full", int'(tx_len), 4);
        fill_req = 0;
        send_check(v, 4, "R7 full");
        ack_check();
    endtask

    task automatic t_zlp();
        logic [DW-1:0] v [4] = '{8'h0, 8'h0, 8'h0, 8'h0};
        fill_req = 1; done = 1; tick(); done = 0; fill_req = 0;
        chk("R5 empty close free", int'(free), 0);
        send_check(v, 0, "R6 zlp");
        ack_check();
    endtask

    task automatic t_wrong_state();
        tok_in = 1; tick(); tok_in = 0;
        chk("R11 no valid", int'(tx_valid), 0);
        chk("R11 no end", int'(tx_end), 0);
        tick();
        chk("R11 no end later", int'(tx_end), 0);
        host_ack = 1; tick(); host_ack = 0;
        chk("R10 ack ignored open", int'(acked), 0);
        fill_req = 0; put = 1; put_data = 8'h77; tick(); put = 0;
        chk("R8 stall without req", int'(stall), 1);
        chk("R8 len no req", int'(tx_len), 0);
        chk("R8 still free", int'(free), 1);
    endtask

    initial begin
        fork
            begin
                repeat (3) tick();
                rst_n = 1;
                tick();
                t_reset();
                t_partial();
                t_full();
                t_zlp();
                t_wrong_state();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule